// File: doc/BRIEF.md
# Dual-Threshold Watchdog Timer

This block is a watchdog counter with two compare points on one count. Each cycle in which a tick strobe is high while the watchdog runs, the count advances by one. When the count reaches the warning threshold, a level interrupt goes up so that software gets a last chance to service the watchdog. When the count reaches the firing threshold, a reset request goes out to the system reset network. Software services the watchdog by writing a kick, which returns the count to zero.

A plain write/read register port reaches five registers: kick, run enable, a sticky status flag, the warning threshold and the firing threshold. A parameter picks one of two address layouts. The status flag records that a firing event took place. It lives on the power-on reset only, so it is still readable after the system reset that the watchdog itself requested. The usual start-up sequence is: clear run enable, kick, load the warning threshold, load the firing threshold, set run enable.

Top module: `dual_stage_wdog`

## Requirements
- R1: Bit 0 of the enable register sets the run state. While the watchdog is stopped the count is held at zero and both `bark_irq` and `bite_req` are low. Writing 0 stops the watchdog, and a later restart counts again from zero.
- R2: A write to the kick register with bit 0 set returns the count to zero. It leaves run enable and both thresholds unchanged. A kick write with bit 0 clear has no effect.
- R3: While running, the count grows by exactly one in each cycle that has `tick` high, and it holds in cycles without a tick.
- R4: `bark_irq` is high whenever the watchdog runs and the count is at or above the warning threshold. It stays high until a kick or a stop.
- R5: `bite_req` is high whenever the watchdog runs and the count is at or above the firing threshold. The count stops advancing once it reaches the firing threshold.
- R6: When both thresholds hold the same value, `bark_irq` and `bite_req` rise in the same cycle.
- R7: Status bit 0 is set in the cycle after `bite_req` is high. It survives `sys_rst_n`. It is cleared by `por_n` or by writing the status register with bit 0 set. A set in the same cycle as a clear write wins.
- R8: The thresholds are 28 bits wide. Write data bits 31:28 are dropped and read back as zero. Both thresholds reset to 0x0FFFFFFF.
- R9: With `LAYOUT`=0 the kick, enable, status, warning and firing registers sit at 0x38, 0x40, 0x44, 0x4C and 0x5C. With `LAYOUT`=1 they sit at 0x04, 0x08, 0x0C, 0x10 and 0x14. Writes to any other address change nothing, and reads of any other address return zero.
- R10: The thresholds can be written while the watchdog is stopped. The values written are the ones used after the next enable.
- R11: `rdata` follows `addr` in the same cycle. The kick register reads zero. The enable and status registers read their flag in bit 0, with all other bits zero.
- R12: `sys_rst_n` clears run enable and the count, and returns both thresholds to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears every register including status |
| sys_rst_n | input | 1 | System reset, active low, asynchronous; clears everything except status |
| tick | input | 1 | Count strobe, one count per high cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (8) | Register byte address |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for `addr` |
| bark_irq | output | 1 | Warning interrupt, level |
| bite_req | output | 1 | System reset request, level |

## Verification
The bench targets the corner cases:
- **Counting past the firing threshold.** The firing threshold is raised after the count has saturated, which exposes a counter that kept going.
- **Kick write with bit 0 clear.** The bench checks that it changes nothing.
- **Status set and clear in the same cycle.** The bench checks that a set coinciding with a clear write still leaves the flag at 1. A design with the priority the wrong way round would lose the record.
- **Status across the system reset.** A design that clears status on `sys_rst_n` would lose the record after the very reset it asked for.
- **Address layouts.** One layout's address is written into the other layout's instance, so a decoder that also matches foreign offsets shows up.
- **Equal thresholds.** Both outputs are checked to rise in the same cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int NREG      = 5;
  localparam int IDX_KICK  = 0;
  localparam int IDX_RUN   = 1;
  localparam int IDX_FLAG  = 2;
  localparam int IDX_WARN  = 3;
  localparam int IDX_FIRE  = 4;

  // byte offset of register idx in the chosen layout
  function automatic logic [7:0] reg_offset(input int layout, input int idx);
    logic [7:0] off;
    if (layout == 0) begin
      case (idx)
        IDX_KICK: off = 8'h38;
        IDX_RUN:  off = 8'h40;
        IDX_FLAG: off = 8'h44;
        IDX_WARN: off = 8'h4C;
        default:  off = 8'h5C;
      endcase
    end else begin
      off = 8'(4 * (idx + 1));
    end
    return off;
  endfunction
endpackage

// File: rtl/wdog_decode.sv
module wdog_decode #(
  parameter int ADDR_W = 8,
  parameter int LAYOUT = 0
) (
  input  logic [ADDR_W-1:0]        addr,
  output logic [wdog_pkg::NREG-1:0] sel
);
  genvar gi;
  generate
    for (gi = 0; gi < wdog_pkg::NREG; gi++) begin : g_hit
      localparam logic [ADDR_W-1:0] OFF = ADDR_W'(wdog_pkg::reg_offset(LAYOUT, gi));
      assign sel[gi] = (addr == OFF);
    end
  endgenerate
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int THR_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             kick,
  input  logic             tick,
  input  logic [THR_W-1:0] warn_thr,
  input  logic [THR_W-1:0] fire_thr,
  output logic             warn_hit,
  output logic             fire_hit
);
  localparam logic [THR_W-1:0] ONE = {{(THR_W-1){1'b0}}, 1'b1};

  logic [THR_W-1:0] count;

  function automatic logic at_or_past(input logic [THR_W-1:0] c, input logic [THR_W-1:0] t);
    return c >= t;
  endfunction

  // saturating step: stops once the firing threshold is reached
  function automatic logic [THR_W-1:0] advance(input logic [THR_W-1:0] c,
                                               input logic [THR_W-1:0] lim,
                                               input logic             tk);
    if (tk && (c < lim)) return c + ONE;
    return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (kick) count <= '0;
    else if (!run) count <= '0;
    else           count <= advance(count, fire_thr, tick);
  end

  assign warn_hit = run && at_or_past(count, warn_thr);
  assign fire_hit = run && at_or_past(count, fire_thr);

  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (count == '0)); // R2
  AST_STOPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !kick) |=> (count == '0)); // R1
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !kick) |=> ((count == $past(count)) || (count == $past(count) + ONE))); // R3
  AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_hit && !kick) |=> (count == $past(count))); // R5
endmodule

// File: rtl/wdog_flag.sv
module wdog_flag (
  input  logic clk,
  input  logic por_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!por_n)
    set_i |=> flag_o); // R7
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (!set_i && !clr_i) |=> $stable(flag_o)); // R7
endmodule

// File: rtl/dual_stage_wdog.sv
module dual_stage_wdog #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int THR_W  = 28,
  parameter int LAYOUT = 0
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              bark_irq,
  output logic              bite_req
);
  import wdog_pkg::*;

  localparam logic [THR_W-1:0] THR_RST = '1;

  logic              ctl_rst_n;
  logic [NREG-1:0]   sel;
  logic              run_q;
  logic [THR_W-1:0]  warn_thr_q, fire_thr_q;
  logic              kick_w, flag_clr_w, flag_q;
  logic              warn_hit, fire_hit;
  logic              unused_wbits;

  assign ctl_rst_n    = por_n & sys_rst_n;
  assign unused_wbits = ^wdata[DATA_W-1:THR_W];

  wdog_decode #(.ADDR_W(ADDR_W), .LAYOUT(LAYOUT)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  assign kick_w     = wr_en && sel[IDX_KICK] && wdata[0];
  assign flag_clr_w = wr_en && sel[IDX_FLAG] && wdata[0];

  always_ff @(posedge clk or negedge ctl_rst_n) begin
    if (!ctl_rst_n) begin
      run_q      <= 1'b0;
      warn_thr_q <= THR_RST;
      fire_thr_q <= THR_RST;
    end else if (wr_en) begin
      if (sel[IDX_RUN])  run_q      <= wdata[0];
      if (sel[IDX_WARN]) warn_thr_q <= wdata[THR_W-1:0];
      if (sel[IDX_FIRE]) fire_thr_q <= wdata[THR_W-1:0];
    end
  end

  wdog_count #(.THR_W(THR_W)) u_cnt (
    .clk      (clk),
    .rst_n    (ctl_rst_n),
    .run      (run_q),
    .kick     (kick_w),
    .tick     (tick),
    .warn_thr (warn_thr_q),
    .fire_thr (fire_thr_q),
    .warn_hit (warn_hit),
    .fire_hit (fire_hit)
  );

  wdog_flag u_flag (
    .clk    (clk),
    .por_n  (por_n),
    .set_i  (fire_hit),
    .clr_i  (flag_clr_w),
    .flag_o (flag_q)
  );

  always_comb begin
    rdata = '0;
    if (sel[IDX_RUN])  rdata[0] = run_q;
    if (sel[IDX_FLAG]) rdata[0] = flag_q;
    if (sel[IDX_WARN]) rdata[THR_W-1:0] = warn_thr_q;
    if (sel[IDX_FIRE]) rdata[THR_W-1:0] = fire_thr_q;
  end

  assign bark_irq = warn_hit;
  assign bite_req = fire_hit;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    $onehot0(sel)); // R9
  AST_KICK_KEEPS_RUN: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    (wr_en && sel[IDX_KICK]) |=> (run_q == $past(run_q))); // R2
  AST_SAME_THR: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    (fire_hit && (warn_thr_q == fire_thr_q)) |-> warn_hit); // R6
  AST_QUIET_STOPPED: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    (!run_q) |-> (!bark_irq && !bite_req)); // R1
endmodule

// File: tb/tb_dual_stage_wdog.sv
module tb_dual_stage_wdog;
  localparam int CLK_PER = 10;
  localparam int K_KICK = 0, K_RUN = 1, K_FLAG = 2, K_WARN = 3, K_FIRE = 4;
  localparam logic [31:0] THR_MAX = 32'h0FFF_FFFF;

  logic clk = 1'b0, por_n = 1'b0, sys_rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr_a = 8'h0, addr_b = 8'h0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata_a, rdata_b;
  logic bark_a, bark_b, bite_a, bite_b;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  dual_stage_wdog #(.LAYOUT(0)) dut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr_a), .wdata(wdata), .rdata(rdata_a), .bark_irq(bark_a), .bite_req(bite_a));
  dual_stage_wdog #(.LAYOUT(1)) dut_b (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr_b), .wdata(wdata), .rdata(rdata_b), .bark_irq(bark_b), .bite_req(bite_b));

  // address map restated from R9
  function automatic logic [7:0] map_off(int k, int r);
    int tab_a[5] = '{56, 64, 68, 76, 92};
    if (k == 0) return 8'(tab_a[r]);
    return 8'(4 + 4 * r);
  endfunction
  function automatic int which_reg(int k, logic [7:0] a);
    for (int r = 0; r < 5; r++) if (map_off(k, r) == a) return r;
    return -1;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference model, one per instance
  bit     m_run[2]  = '{0, 0};
  longint m_cnt[2]  = '{0, 0};
  longint m_warn[2] = '{THR_MAX, THR_MAX};
  longint m_fire[2] = '{THR_MAX, THR_MAX};
  bit     m_flag[2] = '{0, 0};

  function automatic logic [31:0] m_read(int k, logic [7:0] a);
    case (which_reg(k, a))
      K_RUN:  return {31'b0, m_run[k]};
      K_FLAG: return {31'b0, m_flag[k]};
      K_WARN: return 32'(m_warn[k]);
      K_FIRE: return 32'(m_fire[k]);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      logic [7:0] a;
      int  r;
      bit  fired;
      a = (k == 0) ? addr_a : addr_b;
      r = wr_en ? which_reg(k, a) : -1;
      fired = m_run[k] && (m_cnt[k] >= m_fire[k]);
      if (!por_n) begin
        m_flag[k] = 0;
      end else if (fired) begin
        m_flag[k] = 1;
      end else if (r == K_FLAG && wdata[0]) begin
        m_flag[k] = 0;
      end
      if (!por_n || !sys_rst_n) begin
        m_run[k] = 0; m_cnt[k] = 0; m_warn[k] = THR_MAX; m_fire[k] = THR_MAX;
      end else begin
        if (r == K_KICK && wdata[0]) m_cnt[k] = 0;
        else if (!m_run[k]) m_cnt[k] = 0;
        else if (tick && m_cnt[k] < m_fire[k]) m_cnt[k] = m_cnt[k] + 1;
        if (r == K_RUN)  m_run[k]  = wdata[0];
        if (r == K_WARN) m_warn[k] = wdata & THR_MAX;
        if (r == K_FIRE) m_fire[k] = wdata & THR_MAX;
      end
    end
    #(CLK_PER/4);
    for (int k = 0; k < 2; k++) begin
      logic eb, ef;
      eb = m_run[k] && (m_cnt[k] >= m_warn[k]);
      ef = m_run[k] && (m_cnt[k] >= m_fire[k]);
      check("R4", $sformatf("model bark inst%0d", k), {31'b0, (k == 0) ? bark_a : bark_b}, {31'b0, eb});
      check("R5", $sformatf("model bite inst%0d", k), {31'b0, (k == 0) ? bite_a : bite_b}, {31'b0, ef});
      check("R11", $sformatf("model rdata inst%0d", k), (k == 0) ? rdata_a : rdata_b,
            m_read(k, (k == 0) ? addr_a : addr_b));
    end
  end

  task automatic wr(int r, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr_a = map_off(0, r); addr_b = map_off(1, r); wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = 32'h0;
  endtask
  task automatic wr_raw(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr_a = a; addr_b = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = 32'h0;
  endtask
  task automatic rd(int r, output logic [31:0] va, output logic [31:0] vb);
    @(negedge clk);
    addr_a = map_off(0, r); addr_b = map_off(1, r);
    #1; va = rdata_a; vb = rdata_b;
  endtask
  task automatic rd_expect(string req, int r, logic [31:0] exp);
    logic [31:0] va, vb;
    rd(r, va, vb);
    check(req, $sformatf("read reg%0d layout0", r), va, exp);
    check(req, $sformatf("read reg%0d layout1", r), vb, exp);
  endtask
  task automatic ticks(int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask
  task automatic outs(string req, bit eb, bit ef);
    #1;
    check(req, "bark_irq layout0", {31'b0, bark_a}, {31'b0, eb});
    check(req, "bark_irq layout1", {31'b0, bark_b}, {31'b0, eb});
    check(req, "bite_req layout0", {31'b0, bite_a}, {31'b0, ef});
    check(req, "bite_req layout1", {31'b0, bite_b}, {31'b0, ef});
  endtask
  task automatic wrap_up();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      wrap_up();
    end
  end

  initial begin
    logic [31:0] va, vb;
    repeat (3) @(negedge clk);
    por_n = 1'b1; sys_rst_n = 1'b1;
    // reset state (R8, R11)
    rd_expect("R11", K_RUN, 32'h0);
    rd_expect("R8", K_WARN, THR_MAX);
    rd_expect("R8", K_FIRE, THR_MAX);
    rd_expect("R7", K_FLAG, 32'h0);
    outs("R1", 0, 0);
    // start-up sequence, thresholds loaded while stopped (R10)
    wr(K_RUN, 0); wr(K_KICK, 1); wr(K_WARN, 5); wr(K_FIRE, 8);
    rd_expect("R10", K_FIRE, 32'd8);
    wr(K_RUN, 1);
    ticks(4); outs("R4", 0, 0);
    ticks(1); outs("R4", 1, 0);
    ticks(2); outs("R5", 1, 0);
    ticks(1); outs("R10", 1, 1);
    ticks(3); outs("R5", 1, 1);
    // saturation: raising the firing threshold must leave the count at 8 (R5)
    wr(K_FIRE, 10); outs("R5", 1, 0);
    ticks(1); outs("R5", 1, 0);
    ticks(1); outs("R5", 1, 1);
    rd_expect("R7", K_FLAG, 32'h1);
    // kick (R2)
    wr(K_KICK, 1); outs("R2", 0, 0);
    rd_expect("R2", K_RUN, 32'h1);
    rd_expect("R2", K_WARN, 32'd5);
    ticks(5); outs("R4", 1, 0);
    wr(K_KICK, 2); outs("R2", 1, 0);
    // stop and restart from zero (R1)
    wr(K_RUN, 0); outs("R1", 0, 0);
    ticks(6); outs("R1", 0, 0);
    wr(K_RUN, 1);
    ticks(4); outs("R1", 0, 0);
    // ticks with gaps (R3)
    wr(K_KICK, 1);
    for (int i = 0; i < 4; i++) begin
      ticks(1); repeat (2) @(negedge clk);
    end
    outs("R3", 0, 0);
    ticks(1); outs("R3", 1, 0);
    // equal thresholds (R6)
    wr(K_RUN, 0); wr(K_WARN, 3); wr(K_FIRE, 3); wr(K_RUN, 1);
    ticks(2); outs("R6", 0, 0);
    ticks(1); outs("R6", 1, 1);
    // status survives the system reset (R7, R12)
    @(negedge clk); sys_rst_n = 1'b0;
    @(negedge clk); sys_rst_n = 1'b1;
    rd_expect("R7", K_FLAG, 32'h1);
    rd_expect("R12", K_RUN, 32'h0);
    rd_expect("R12", K_WARN, THR_MAX);
    outs("R12", 0, 0);
    wr(K_FLAG, 1);
    rd_expect("R7", K_FLAG, 32'h0);
    // set wins over a simultaneous clear (R7)
    wr(K_WARN, 2); wr(K_FIRE, 2); wr(K_RUN, 1);
    ticks(2); outs("R6", 1, 1);
    wr(K_FLAG, 1);
    rd_expect("R7", K_FLAG, 32'h1);
    wr(K_RUN, 0); wr(K_FLAG, 1);
    rd_expect("R7", K_FLAG, 32'h0);
    // power-on reset clears status (R7)
    wr(K_RUN, 1); ticks(2);
    rd_expect("R7", K_FLAG, 32'h1);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    rd_expect("R7", K_FLAG, 32'h0);
    // upper write bits dropped (R8)
    wr(K_WARN, 32'hF000_0007);
    rd_expect("R8", K_WARN, 32'd7);
    // unmapped address and per-layout decode (R9)
    wr_raw(8'h20, 32'h1);
    rd_expect("R9", K_RUN, 32'h0);
    @(negedge clk); addr_a = 8'h20; addr_b = 8'h20; #1;
    check("R9", "unmapped read layout0", rdata_a, 32'h0);
    check("R9", "unmapped read layout1", rdata_b, 32'h0);
    wr_raw(8'h40, 32'h1);
    rd(K_RUN, va, vb);
    check("R9", "layout0 enable at 0x40", va, 32'h1);
    check("R9", "layout1 ignores 0x40", vb, 32'h0);
    rd_expect("R11", K_KICK, 32'h0);
    repeat (2) @(negedge clk);
    wrap_up();
  end
endmodule